// File: doc/BRIEF.md
# I2C Bus Control and Monitor Register

This block is one 8-bit control and status register for an I2C master. Software uses it to ask for start and stop conditions, to pulse a reset into the protocol engine, and to take direct control of the SDA line so that a hung bus can be recovered. The block also watches the live SCL and SDA pins. It reports whether the bus is occupied and shows the present SCL level.

Every write is gated by interlock bits. The busy bit and the SDA output bit are each paired with a protect bit, and the paired field acts only when its protect bit is written as 0 in the same write. Pin inputs pass through a two-flop synchroniser. The bus-occupied flag then follows start and stop conditions, which are found by comparing each synchronised sample with the one before it.

Top module: `i2c_busctl_reg`

## Requirements
- R1: After reset, rd_data reads 0x7D, sda_oe is 0 (SDA released), bus_busy is 0, and start_req, stop_req and ctl_rst are 0.
- R2: A fall of sda_in while scl_in is high sets bus_busy. The change shows three rising clock edges after the pin change and is not yet visible after two.
- R3: A rise of sda_in while scl_in is high clears bus_busy after the same three-edge latency. SDA edges while scl_in is low leave bus_busy unchanged.
- R4: With master_mode high, a write with bit 6 = 0 and bit 7 = 1 gives a one-cycle start_req. A write with bit 6 = 0 and bit 7 = 0 gives a one-cycle stop_req. Each pulse is high in the cycle after the write edge.
- R5: A write with bit 6 = 1 gives neither start_req nor stop_req. Bits 6, 4, 2 and 0 always read as 1.
- R6: A write with bit 4 = 0 loads the held SDA level from bit 5. A held level of 0 drives sda_oe = 1, and a held level of 1 gives sda_oe = 0. A write with bit 4 = 1 leaves the held level unchanged. Bit 5 of rd_data reads back the held level.
- R7: Bit 3 of rd_data reports the scl_in level two rising edges after it changes. Bit 7 reads bus_busy.
- R8: A write with bit 1 = 1 gives a one-cycle ctl_rst in the cycle after the write edge and leaves the held SDA level unchanged. Bit 1 always reads 0.
- R9: With master_mode low, writes give neither start_req nor stop_req.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Register read value |
| master_mode | input | 1 | High when the engine acts as master |
| scl_in | input | 1 | Live SCL pin level |
| sda_in | input | 1 | Live SDA pin level |
| sda_oe | output | 1 | Pulls SDA low when 1 (open drain) |
| start_req | output | 1 | Start condition request pulse |
| stop_req | output | 1 | Stop condition request pulse |
| ctl_rst | output | 1 | Protocol engine reset pulse |
| bus_busy | output | 1 | Bus occupied flag |

## Verification
Write results are due one rising edge after the write. The request and reset pulses and the held SDA level all appear then, and each pulse is checked again one cycle later to confirm it has dropped. A pin change reaches the SCL monitor bit after two rising edges and reaches bus_busy after three. The bench therefore samples at the falling edge after exactly that many edges, and it also checks the busy flag one edge early to confirm it has not yet moved. All inputs are driven on falling edges, so every sample falls between active edges.

// File: rtl/i2c_busctl_reg.sv
module i2c_busctl_reg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  input  logic       master_mode,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       sda_oe,
  output logic       start_req,
  output logic       stop_req,
  output logic       ctl_rst,
  output logic       bus_busy
);

  logic [1:0] scl_sync, sda_sync;
  logic       scl_prev, sda_prev;
  logic       sda_hold;
  logic       unused_bits;

  wire scl_s   = scl_sync[1];
  wire sda_s   = sda_sync[1];
  wire saw_start = scl_s && scl_prev && sda_prev && !sda_s;
  wire saw_stop  = scl_s && scl_prev && !sda_prev && sda_s;
  wire ss_ok   = wr_en && !wr_data[6] && master_mode;

  assign unused_bits = ^{wr_data[3], wr_data[2], wr_data[0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sync <= 2'b11;
      sda_sync <= 2'b11;
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_sync <= {scl_sync[0], scl_in};
      sda_sync <= {sda_sync[0], sda_in};
      scl_prev <= scl_s;
      sda_prev <= sda_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         bus_busy <= 1'b0;
    else if (saw_start) bus_busy <= 1'b1;
    else if (saw_stop)  bus_busy <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sda_hold  <= 1'b1;
      start_req <= 1'b0;
      stop_req  <= 1'b0;
      ctl_rst   <= 1'b0;
    end else begin
      if (wr_en && !wr_data[4]) sda_hold <= wr_data[5];
      start_req <= ss_ok && wr_data[7];
      stop_req  <= ss_ok && !wr_data[7];
      ctl_rst   <= wr_en && wr_data[1];
    end
  end

  assign sda_oe  = !sda_hold;
  assign rd_data = {bus_busy, 1'b1, sda_hold, 1'b1, scl_s, 1'b1, 1'b0, 1'b1};

  a_r4_start_from_write: assert property (@(posedge clk) disable iff (!rst_n)
    start_req |-> ($past(wr_en) && !$past(wr_data[6]) && $past(wr_data[7])));

  a_r9_master_only: assert property (@(posedge clk) disable iff (!rst_n)
    (start_req || stop_req) |-> $past(master_mode));

  a_r6_sda_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && !wr_data[4]) |=> $stable(sda_oe));

  a_r8_ctl_rst_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_rst |-> $past(wr_en) && $past(wr_data[1]));

  a_r2_busy_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_busy) |-> $past(scl_prev) && !$past(sda_s));

  a_r4_no_both: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_req && stop_req));

endmodule

// File: tb/test_i2c_busctl_reg.sv
module test_i2c_busctl_reg;
  localparam int PERIOD = 10;

  logic clk = 0, rst_n = 0, wr_en = 0, master_mode = 1, scl_in = 1, sda_in = 1;
  logic [7:0] wr_data = 0;
  logic [7:0] rd_data;
  logic sda_oe, start_req, stop_req, ctl_rst, bus_busy;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  i2c_busctl_reg i_i2c_busctl_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .master_mode(master_mode), .scl_in(scl_in), .sda_in(sda_in), .sda_oe(sda_oe),
    .start_req(start_req), .stop_req(stop_req), .ctl_rst(ctl_rst), .bus_busy(bus_busy));

  // {wdata[7:0], master, exp_start, exp_stop, exp_ctl, exp_oe}
  localparam logic [12:0] VEC [0:7] = '{
    {8'hB0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},   // R4 start
    {8'h30, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},   // R4 stop
    {8'hC0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1},   // R5 ignored, R6 drive low
    {8'h20, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},   // R6 release + stop
    {8'h80, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},   // R9 no start
    {8'h10, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},   // R9 no stop, R6 protected
    {8'h32, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1},   // R8 ctl reset, hold unchanged
    {8'h70, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1}    // R5 all protected
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_edges(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    wait_edges(2);
    chk("R1 rd_data", rd_data, 8'h7D);
    chk("R1 sda_oe", sda_oe, 0);
    chk("R1 pulses", {start_req, stop_req, ctl_rst, bus_busy}, 0);
    rst_n = 1;
    wait_edges(2);

    for (int i = 0; i < 8; i++) begin
      logic [7:0] w;
      w = VEC[i][12:5];
      wr_data = w; master_mode = VEC[i][4]; wr_en = 1;
      wait_edges(1);
      wr_en = 0;
      chk("R4/R9 start_req", start_req, VEC[i][3]);
      chk("R4/R9 stop_req", stop_req, VEC[i][2]);
      chk("R8 ctl_rst", ctl_rst, VEC[i][1]);
      chk("R6 sda_oe", sda_oe, VEC[i][0]);
      chk("R5/R6/R8 rd_data", rd_data, {1'b0, 1'b1, ~VEC[i][0], 1'b1, 1'b1, 1'b1, 1'b0, 1'b1});
      wait_edges(1);
      chk("R4/R8 pulses dropped", {start_req, stop_req, ctl_rst}, 0);
    end

    // release SDA without a start/stop request
    master_mode = 1; wr_data = 8'h60; wr_en = 1;
    wait_edges(1); wr_en = 0;
    chk("R6 release", sda_oe, 0);
    chk("R5 no request", {start_req, stop_req}, 0);

    // R7 SCL monitor latency
    scl_in = 0;
    wait_edges(1);
    chk("R7 scl not yet", rd_data[3], 1);
    wait_edges(1);
    chk("R7 scl low", rd_data[3], 0);
    scl_in = 1;
    wait_edges(2);
    chk("R7 scl high", rd_data[3], 1);
    wait_edges(2);

    // R2 start condition
    sda_in = 0;
    wait_edges(2);
    chk("R2 busy not yet", bus_busy, 0);
    wait_edges(1);
    chk("R2 busy set", bus_busy, 1);
    chk("R7 busy in rd", rd_data[7], 1);

    // R3 SDA toggles with SCL low
    scl_in = 0; wait_edges(4);
    sda_in = 1; wait_edges(4);
    chk("R3 busy kept on rise low scl", bus_busy, 1);
    sda_in = 0; wait_edges(4);
    chk("R3 busy kept on fall low scl", bus_busy, 1);
    scl_in = 1; wait_edges(4);

    // R3 stop condition
    sda_in = 1;
    wait_edges(2);
    chk("R3 busy not yet cleared", bus_busy, 1);
    wait_edges(1);
    chk("R3 busy cleared", bus_busy, 0);

    // R3 SDA fall with SCL low does not set busy
    scl_in = 0; wait_edges(4);
    sda_in = 0; wait_edges(4);
    chk("R3 no set on low scl", bus_busy, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule